// File: doc/BRIEF.md
# Secure Session Privilege Tracker

This block holds the security state of a session with a protected memory. It follows the communication security mode (plain, authenticated, encrypted), remembers which password set was last verified and whether it was a read or a write password, and counts failed verification attempts for every password set and every key set. Verification results come in as single-cycle event pulses from the surrounding crypto and command logic. Each pulse carries a raw pass or fail flag and the index of the set it concerns.

For one requested zone, the block combines the held state with that zone's configuration and registers a read grant and a write grant. The zone configuration says whether a password set is needed, whether authentication with a given key set is needed, and whether encrypted mode is needed. The command logic reads the grants before it lets a zone access reach storage.

Top module: `sess_priv_tracker`

## Requirements
- R1: While `rst` is high, `mode` is 0 (plain) and both grants are low. `rst` also clears every attempt counter.
- R2: A successful authentication sets `mode` to 1 (authenticated) and records its key set. A failed authentication sets `mode` to 0, which drops any earlier authentication or encryption.
- R3: An encryption activation sets `mode` to 2 (encrypted) only when all three hold: its raw flag passes, the mode is not 0, and its key index equals the recorded key set. Any other encryption activation sets `mode` to 0.
- R4: A MAC mismatch (`mac_evt` with `mac_ok` low) in mode 1 or 2 sets `mode` to 0. In mode 0 it has no effect. A MAC match has no effect in any mode. Neither kind of MAC event touches the held password.
- R5: Only one password is held. Every presentation replaces the held one, and a failed presentation leaves none held.
- R6: A held read password (`pw_write` = 0) grants read only, to zones whose configured set matches. A held write password (`pw_write` = 1) grants both read and write.
- R7: A zone's grants are high only when every requirement enabled for it is met. The password requirement is met by a matching held set. The authentication requirement is met by mode 1 or 2 with the configured key set. The encryption requirement is met by mode 2 only. A zone with nothing enabled is always granted.
- R8: Each password set and each key set has its own 4-bit attempt counter. A failure adds one, saturating at 15. A success resets the counter to 0. Once a counter has reached `ATTEMPT_LIMIT`, every later attempt on that set counts as a failure, even when the raw flag passes.
- R9: A high `card_rst` returns `mode` to 0 and drops the held password. It leaves the attempt counters as they were.
- R10: `mode` changes on the clock edge that samples an event. The grants follow on the next edge, so they lag `mode` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| card_rst | input | 1 | Session reset line, synchronous, active high |
| auth_evt | input | 1 | Authentication result pulse |
| auth_pass | input | 1 | Raw authentication result |
| auth_key | input | KEY_W | Key set of the authentication |
| enc_evt | input | 1 | Encryption activation pulse |
| enc_pass | input | 1 | Raw activation result |
| enc_key | input | KEY_W | Key set of the activation |
| pw_evt | input | 1 | Password presentation pulse |
| pw_pass | input | 1 | Raw password comparison result |
| pw_write | input | 1 | 1 for a write password, 0 for a read password |
| pw_set | input | PW_W | Password set presented |
| mac_evt | input | 1 | MAC check pulse |
| mac_ok | input | 1 | MAC matched |
| zone_sel | input | ZONE_W | Zone whose grants are requested |
| cfg_pw_en | input | NUM_ZONES | Zone needs a password |
| cfg_pw_set | input | NUM_ZONES*PW_W | Password set per zone, zone z at bits z*PW_W upward |
| cfg_auth_en | input | NUM_ZONES | Zone needs authentication |
| cfg_auth_key | input | NUM_ZONES*KEY_W | Key set per zone, zone z at bits z*KEY_W upward |
| cfg_enc_req | input | NUM_ZONES | Zone needs encrypted mode |
| mode | output | 2 | 0 plain, 1 authenticated, 2 encrypted |
| rd_grant | output | 1 | Read allowed for the selected zone |
| wr_grant | output | 1 | Write allowed for the selected zone |

## Verification
The bench targets the ways privilege can be revoked.

- A failed re-authentication, a mismatched encryption key, or encryption without prior authentication must all leave mode 0. A design that kept the old state would still grant the authenticated zones.
- A MAC mismatch must clear the mode but not the held password. The bench presents a write password, sends a mismatch in mode 0, and expects the password zone to stay granted.

Attempt counters are checked on both sides of the limit:

- A correct value presented after three failures must be refused.
- A success must reset the count, shown by a pass after two failures, a second pair of failures, and a final pass that must still be accepted.
- A counter that `card_rst` cleared, or one that `rst` left standing, shows up as a key-set grant that is wrongly present or wrongly missing.

// File: rtl/sess_pkg.sv
package sess_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } sec_mode_e;
endpackage

// File: rtl/sess_attempt_ctr.sv
module sess_attempt_ctr #(
  parameter int N      = 8,
  parameter int CNT_W  = 4,
  parameter int LIMIT  = 3,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [IDX_W-1:0] idx,
  input  logic             pass_in,
  output logic             pass_eff
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q [N];
  logic [IDX_W-1:0] idx_d;

  // a locked set refuses even a correct value
  assign pass_eff = pass_in && (cnt_q[idx] < LIM);

  always_ff @(posedge clk) begin
    idx_d <= idx;
    if (rst) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else if (evt) begin
      if (pass_eff)                 cnt_q[idx] <= '0;
      else if (cnt_q[idx] != CNT_MAX) cnt_q[idx] <= cnt_q[idx] + 1'b1;
    end
  end

  // R8
  ctr_clear_on_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && pass_eff) |=> (cnt_q[idx_d] == '0));
  // R8
  ctr_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !pass_eff && cnt_q[idx] == CNT_MAX) |=> (cnt_q[idx_d] == CNT_MAX));
endmodule

// File: rtl/sess_mode_fsm.sv
module sess_mode_fsm
  import sess_pkg::*;
#(
  parameter int KEY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             card_rst,
  input  logic             auth_evt,
  input  logic             auth_ok,
  input  logic [KEY_W-1:0] auth_key,
  input  logic             enc_evt,
  input  logic             enc_pass,
  input  logic [KEY_W-1:0] enc_key,
  input  logic             mac_evt,
  input  logic             mac_ok,
  output sec_mode_e        mode_o,
  output logic [KEY_W-1:0] key_o
);
  sec_mode_e        mode_q;
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (rst || card_rst) begin
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (auth_evt) begin
      if (auth_ok) begin
        mode_q <= MODE_AUTH;
        key_q  <= auth_key;
      end else begin
        mode_q <= MODE_STD;
      end
    end else if (enc_evt) begin
      if (enc_pass && mode_q != MODE_STD && enc_key == key_q) mode_q <= MODE_ENC;
      else                                                     mode_q <= MODE_STD;
    end else if (mac_evt && !mac_ok) begin
      mode_q <= MODE_STD;
    end
  end

  assign mode_o = mode_q;
  assign key_o  = key_q;

  // R3
  enc_from_auth_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ENC && $past(mode_q) != MODE_ENC) |-> ($past(mode_q) == MODE_AUTH));
  // R4
  mac_revoke_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_evt && !mac_ok && !auth_evt && !enc_evt) |=> (mode_q == MODE_STD));
  // R9
  card_rst_chk: assert property (@(posedge clk) disable iff (rst)
    card_rst |=> (mode_q == MODE_STD));
endmodule

// File: rtl/sess_pw_hold.sv
module sess_pw_hold #(
  parameter int PW_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            card_rst,
  input  logic            pw_evt,
  input  logic            pw_ok,
  input  logic            pw_write,
  input  logic [PW_W-1:0] pw_set,
  output logic            held_o,
  output logic            held_wr_o,
  output logic [PW_W-1:0] held_set_o
);
  always_ff @(posedge clk) begin
    if (rst || card_rst) begin
      held_o     <= 1'b0;
      held_wr_o  <= 1'b0;
      held_set_o <= '0;
    end else if (pw_evt) begin
      held_o     <= pw_ok;
      held_wr_o  <= pw_ok && pw_write;
      held_set_o <= pw_set;
    end
  end

  // R5
  pw_fail_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pw_evt && !pw_ok) |=> !held_o);
endmodule

// File: rtl/sess_priv_tracker.sv
module sess_priv_tracker
  import sess_pkg::*;
#(
  parameter int NUM_ZONES     = 8,
  parameter int NUM_PW_SETS   = 8,
  parameter int NUM_KEY_SETS  = 4,
  parameter int CNT_W         = 4,
  parameter int ATTEMPT_LIMIT = 3,
  parameter int ZONE_W        = $clog2(NUM_ZONES),
  parameter int PW_W          = $clog2(NUM_PW_SETS),
  parameter int KEY_W         = $clog2(NUM_KEY_SETS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        card_rst,
  input  logic                        auth_evt,
  input  logic                        auth_pass,
  input  logic [KEY_W-1:0]            auth_key,
  input  logic                        enc_evt,
  input  logic                        enc_pass,
  input  logic [KEY_W-1:0]            enc_key,
  input  logic                        pw_evt,
  input  logic                        pw_pass,
  input  logic                        pw_write,
  input  logic [PW_W-1:0]             pw_set,
  input  logic                        mac_evt,
  input  logic                        mac_ok,
  input  logic [ZONE_W-1:0]           zone_sel,
  input  logic [NUM_ZONES-1:0]        cfg_pw_en,
  input  logic [NUM_ZONES*PW_W-1:0]   cfg_pw_set,
  input  logic [NUM_ZONES-1:0]        cfg_auth_en,
  input  logic [NUM_ZONES*KEY_W-1:0]  cfg_auth_key,
  input  logic [NUM_ZONES-1:0]        cfg_enc_req,
  output logic [1:0]                  mode,
  output logic                        rd_grant,
  output logic                        wr_grant
);
  logic             auth_ok, pw_ok;
  sec_mode_e        mode_q;
  logic [KEY_W-1:0] key_q;
  logic             held, held_wr;
  logic [PW_W-1:0]  held_set;
  logic [NUM_ZONES-1:0] z_rd, z_wr;

  sess_attempt_ctr #(.N(NUM_KEY_SETS), .CNT_W(CNT_W), .LIMIT(ATTEMPT_LIMIT), .IDX_W(KEY_W)) u_key_ctr (
    .clk(clk), .rst(rst), .evt(auth_evt), .idx(auth_key), .pass_in(auth_pass), .pass_eff(auth_ok));

  sess_attempt_ctr #(.N(NUM_PW_SETS), .CNT_W(CNT_W), .LIMIT(ATTEMPT_LIMIT), .IDX_W(PW_W)) u_pw_ctr (
    .clk(clk), .rst(rst), .evt(pw_evt), .idx(pw_set), .pass_in(pw_pass), .pass_eff(pw_ok));

  sess_mode_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk(clk), .rst(rst), .card_rst(card_rst),
    .auth_evt(auth_evt), .auth_ok(auth_ok), .auth_key(auth_key),
    .enc_evt(enc_evt), .enc_pass(enc_pass), .enc_key(enc_key),
    .mac_evt(mac_evt), .mac_ok(mac_ok), .mode_o(mode_q), .key_o(key_q));

  sess_pw_hold #(.PW_W(PW_W)) u_pw (
    .clk(clk), .rst(rst), .card_rst(card_rst), .pw_evt(pw_evt), .pw_ok(pw_ok),
    .pw_write(pw_write), .pw_set(pw_set),
    .held_o(held), .held_wr_o(held_wr), .held_set_o(held_set));

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    logic pw_match, auth_met, enc_met, pw_rd_met, pw_wr_met;
    assign pw_match  = held && (held_set == cfg_pw_set[z*PW_W +: PW_W]);
    assign auth_met  = !cfg_auth_en[z] ||
                       (mode_q != MODE_STD && key_q == cfg_auth_key[z*KEY_W +: KEY_W]);
    assign enc_met   = !cfg_enc_req[z] || (mode_q == MODE_ENC);
    assign pw_rd_met = !cfg_pw_en[z] || pw_match;
    assign pw_wr_met = !cfg_pw_en[z] || (pw_match && held_wr);
    assign z_rd[z]   = auth_met && enc_met && pw_rd_met;
    assign z_wr[z]   = auth_met && enc_met && pw_wr_met;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_grant <= 1'b0;
      wr_grant <= 1'b0;
    end else begin
      rd_grant <= z_rd[zone_sel];
      wr_grant <= z_wr[zone_sel];
    end
  end

  assign mode = mode_q;

  // R6
  wr_implies_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_grant |-> rd_grant);
  // R7
  enc_zone_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_enc_req[zone_sel] && mode_q != MODE_ENC) |=> !rd_grant);
endmodule

// File: tb/sess_priv_tracker_tb.sv
`timescale 1ns/1ps
module sess_priv_tracker_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, card_rst, auth_evt, auth_pass, enc_evt, enc_pass;
  logic pw_evt, pw_pass, pw_write, mac_evt, mac_ok;
  logic [1:0] auth_key, enc_key, mode;
  logic [2:0] pw_set, zone_sel;
  logic [7:0] cfg_pw_en, cfg_auth_en, cfg_enc_req;
  logic [23:0] cfg_pw_set;
  logic [15:0] cfg_auth_key;
  logic rd_grant, wr_grant;
  int n_chk = 0, n_fail = 0;

  sess_priv_tracker u_dut (
    .clk(clk), .rst(rst), .card_rst(card_rst),
    .auth_evt(auth_evt), .auth_pass(auth_pass), .auth_key(auth_key),
    .enc_evt(enc_evt), .enc_pass(enc_pass), .enc_key(enc_key),
    .pw_evt(pw_evt), .pw_pass(pw_pass), .pw_write(pw_write), .pw_set(pw_set),
    .mac_evt(mac_evt), .mac_ok(mac_ok), .zone_sel(zone_sel),
    .cfg_pw_en(cfg_pw_en), .cfg_pw_set(cfg_pw_set), .cfg_auth_en(cfg_auth_en),
    .cfg_auth_key(cfg_auth_key), .cfg_enc_req(cfg_enc_req),
    .mode(mode), .rd_grant(rd_grant), .wr_grant(wr_grant));

  // fields: req[18:15] kind[14:12] idx[11:9] wr[8] pass[7] zone[6:4] mode[3:2] rd[1] wr[0]
  // kind: 0 none, 1 auth, 2 enc, 3 password, 4 MAC mismatch, 5 MAC match
  localparam int NV = 34;
  localparam logic [18:0] VEC [NV] = '{
    {4'd7, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 1'b1}, // R7 open zone
    {4'd7, 3'd0, 3'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0}, // R7 password zone closed
    {4'd6, 3'd3, 3'd2, 1'b0, 1'b1, 3'd1, 2'd0, 1'b1, 1'b0}, // R6 read password
    {4'd6, 3'd3, 3'd2, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 1'b1}, // R6 write password
    {4'd5, 3'd3, 3'd3, 1'b1, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0}, // R5 replaced
    {4'd2, 3'd1, 3'd1, 1'b0, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1}, // R2 auth key1
    {4'd7, 3'd0, 3'd0, 1'b0, 1'b0, 3'd3, 2'd1, 1'b0, 1'b0}, // R7 enc needed
    {4'd3, 3'd2, 3'd1, 1'b0, 1'b1, 3'd3, 2'd2, 1'b1, 1'b1}, // R3 enc on
    {4'd4, 3'd5, 3'd0, 1'b0, 1'b0, 3'd3, 2'd2, 1'b1, 1'b1}, // R4 MAC match
    {4'd4, 3'd4, 3'd0, 1'b0, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0}, // R4 MAC mismatch
    {4'd3, 3'd2, 3'd1, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0}, // R3 no auth first
    {4'd2, 3'd1, 3'd1, 1'b0, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1}, // R2
    {4'd3, 3'd2, 3'd2, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0}, // R3 key mismatch
    {4'd2, 3'd1, 3'd1, 1'b0, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1}, // R2
    {4'd2, 3'd1, 3'd0, 1'b0, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0}, // R2 failed re-auth
    {4'd7, 3'd1, 3'd3, 1'b0, 1'b1, 3'd4, 2'd1, 1'b0, 1'b0}, // R7 auth but no pw
    {4'd6, 3'd3, 3'd5, 1'b0, 1'b1, 3'd4, 2'd1, 1'b1, 1'b0}, // R6
    {4'd4, 3'd4, 3'd0, 1'b0, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0}, // R4
    {4'd6, 3'd3, 3'd2, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 1'b1}, // R6
    {4'd4, 3'd4, 3'd0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b1, 1'b1}, // R4 no effect in plain mode
    {4'd8, 3'd1, 3'd0, 1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0}, // R8 key0 count 2
    {4'd8, 3'd1, 3'd0, 1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 1'b0}, // R8 key0 count 3
    {4'd8, 3'd1, 3'd0, 1'b0, 1'b1, 3'd7, 2'd0, 1'b0, 1'b0}, // R8 locked
    {4'd8, 3'd1, 3'd1, 1'b0, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1}, // R8 other set free
    {4'd8, 3'd3, 3'd6, 1'b1, 1'b0, 3'd6, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd6, 1'b1, 1'b0, 3'd6, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd6, 1'b1, 1'b0, 3'd6, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd6, 1'b1, 1'b1, 3'd6, 2'd1, 1'b0, 1'b0}, // R8 pw locked
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b1, 3'd1, 2'd1, 1'b1, 1'b1}, // R8 success clears
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b0, 3'd1, 2'd1, 1'b0, 1'b0}, // R8
    {4'd8, 3'd3, 3'd2, 1'b1, 1'b1, 3'd1, 2'd1, 1'b1, 1'b1}  // R8 still below limit
  };

  task automatic chk(input int req, input logic [1:0] em, input logic er, input logic ew);
    n_chk++;
    if (mode !== em || rd_grant !== er || wr_grant !== ew) begin
      n_fail++;
      $display("FAIL R%0d: mode=%0d rd=%0b wr=%0b expected mode=%0d rd=%0b wr=%0b",
               req, mode, rd_grant, wr_grant, em, er, ew);
    end
  endtask

  task automatic drive(input logic [2:0] kind, input logic [2:0] idx, input logic w,
                       input logic p, input logic [2:0] z);
    @(negedge clk);
    zone_sel = z;
    auth_key = idx[1:0]; enc_key = idx[1:0]; pw_set = idx;
    auth_pass = p; enc_pass = p; pw_pass = p; pw_write = w;
    auth_evt = (kind == 3'd1); enc_evt = (kind == 3'd2); pw_evt = (kind == 3'd3);
    mac_evt = (kind == 3'd4) || (kind == 3'd5); mac_ok = (kind == 3'd5);
    @(negedge clk);
    auth_evt = 0; enc_evt = 0; pw_evt = 0; mac_evt = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1; card_rst = 0; auth_evt = 0; auth_pass = 0; enc_evt = 0; enc_pass = 0;
    pw_evt = 0; pw_pass = 0; pw_write = 0; mac_evt = 0; mac_ok = 0;
    auth_key = 0; enc_key = 0; pw_set = 0; zone_sel = 0;
    cfg_pw_en = 8'b0101_0010; cfg_auth_en = 8'b1001_1100; cfg_enc_req = 8'b0000_1000;
    cfg_pw_set = '0; cfg_pw_set[5:3] = 3'd2; cfg_pw_set[14:12] = 3'd5; cfg_pw_set[20:18] = 3'd6;
    cfg_auth_key = '0; cfg_auth_key[5:4] = 2'd1; cfg_auth_key[7:6] = 2'd1;
    cfg_auth_key[9:8] = 2'd3; cfg_auth_key[15:14] = 2'd0;
    repeat (3) @(negedge clk);
    chk(1, 2'd0, 1'b0, 1'b0); // R1 reset state
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:12], VEC[i][11:9], VEC[i][8], VEC[i][7], VEC[i][6:4]);
      @(negedge clk);
      chk(int'(VEC[i][18:15]), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R9: session reset clears mode and password
    @(negedge clk); card_rst = 1; zone_sel = 3'd1;
    @(negedge clk); card_rst = 0;
    @(negedge clk);
    chk(9, 2'd0, 1'b0, 1'b0);
    // R9: key0 counter survives session reset, still locked
    drive(3'd1, 3'd0, 1'b0, 1'b1, 3'd7);
    @(negedge clk);
    chk(9, 2'd0, 1'b0, 1'b0);

    // R1: power-on reset, hold and check, then counters are clear
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk(1, 2'd0, 1'b0, 1'b0);
    rst = 0;
    // R10: mode moves one cycle ahead of the grants
    @(negedge clk);
    zone_sel = 3'd7; auth_key = 2'd0; auth_pass = 1; auth_evt = 1;
    @(negedge clk);
    auth_evt = 0;
    chk(10, 2'd1, 1'b0, 1'b0);
    @(negedge clk);
    chk(1, 2'd1, 1'b1, 1'b1); // R1 key0 unlocked after power-on reset

    summary();
    $finish;
  end
endmodule